// File: doc/BRIEF.md
# General-Purpose I/O Bank with Interrupt Detection

This block is one bank of 32 general-purpose pins seen through a small word-indexed register bus with separate read and write strobes. Software sets each pin's direction and output level, reads the synchronised input level, and picks for each pin how it raises an interrupt. The choices are a low level, a high level, a rising edge or a falling edge. A per-pin override makes the pin respond to any edge.

Every pin input passes through a synchroniser before it is used. Detected conditions set sticky status bits, which software clears by writing ones. A per-pin mask gates each status bit onto one of two interrupt request lines. One line serves the lower sixteen pins and the other serves the upper sixteen, so an interrupt controller can treat the halves as separate sources.

The bus carries a 3-bit word index, so index k is the register at byte offset 4·k. A read returns its data on `bus_rdata` on the clock edge that samples `bus_rd`, and the value holds until the next read.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, the registers at these indices read 0: 0 (output data), 1 (direction), 5 (mask), 6 (status) and 7 (edge select). Both configuration words (indices 3 and 4) read 0x55555555, so every pin is in high-level mode. `pin_out` and `pin_oe` are 0.
- R2: A write to index 0 sets `pin_out`, and a write to index 1 sets `pin_oe`, from the cycle after the write strobe. A direction bit of 1 makes the pin an output. Both registers read back what was written.
- R3: Index 2 reads each pin's input level after a two-stage synchroniser. A read strobed in the cycle after the input changes still returns the old level, and the next read returns the new level. Writes to index 2 have no effect.
- R4: In the level modes (field value 0 = low, 1 = high), a pin's status bit is set on every cycle that its synchronised level matches the mode. The bit stays set after the level goes away.
- R5: In the edge modes (field value 2 = rising, 3 = falling), a pin's status bit is set once for each matching change between the synchronised level and its value on the previous cycle. An edge in the other direction sets nothing.
- R6: Edge-select bit n at index 7 set to 1 makes pin n set its status bit on any edge, and its mode field is then ignored. A pin held at a steady level sets nothing, even in a level mode.
- R7: Writing a 1 to bit n of the status register (index 6) clears status bit n. Bits written 0 keep their value, and writing 0xFFFFFFFF clears every bit that has no new event.
- R8: `irq_lo` is the OR over pins 0 to 15 of status AND mask (mask at index 5). `irq_hi` is the same OR over pins 16 to 31. With a mask bit at 0, that pin's status cannot raise a line.
- R9: When a clear and a new event hit the same status bit in the same cycle, the bit ends up set.
- R10: Pin n's 2-bit mode field sits at bits [2n+1:2n] of index 3 for pins 0 to 15, and at bits [2(n-16)+1:2(n-16)] of index 4 for pins 16 to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 3 | Register word index |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Asynchronous pad input levels |
| pin_out | output | 32 | Output data driven to pads |
| pin_oe | output | 32 | Output enable per pin (1 = output) |
| irq_lo | output | 1 | Interrupt request for pins 0 to 15 |
| irq_hi | output | 1 | Interrupt request for pins 16 to 31 |

## Verification
The bench builds the bank with its default two-stage synchroniser and the full 32-pin width. This makes the two-read latency of the pad register measurable, and the R9 clear can be placed on the exact cycle an edge event arrives. Because all 32 pins are present, directed tests cover pins in both interrupt groups and mode fields in both configuration words (pins 5, 6 and 20). A random phase then mixes pin toggles with writes of random data to every register. Its reference model is clocked every cycle, so both request lines, the pin outputs and every read are compared while all four modes and edge select are in use.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int NUM_PINS  = 32;
    localparam int WORD_W    = 32;
    localparam int MODE_W    = 2;
    localparam int IDX_W     = 3;
    localparam int GROUP_W   = NUM_PINS / 2;
    localparam int CFG_W     = NUM_PINS * MODE_W;
    localparam int CFG_WORDS = CFG_W / WORD_W;

    typedef enum logic [MODE_W-1:0] {
        TRG_LOW  = 2'd0,
        TRG_HIGH = 2'd1,
        TRG_RISE = 2'd2,
        TRG_FALL = 2'd3
    } trig_mode_e;

    typedef enum logic [IDX_W-1:0] {
        RG_DOUT   = 3'd0,
        RG_DIR    = 3'd1,
        RG_PAD    = 3'd2,
        RG_CFG_LO = 3'd3,
        RG_CFG_HI = 3'd4,
        RG_MASK   = 3'd5,
        RG_STAT   = 3'd6,
        RG_ESEL   = 3'd7
    } reg_idx_e;

    localparam logic [CFG_W-1:0] CFG_RESET = {NUM_PINS{TRG_HIGH}};

    function automatic logic trig_hit(trig_mode_e mode, logic any_edge,
                                      logic cur, logic prev);
        logic hit;
        if (any_edge) begin
            hit = cur ^ prev;
        end else begin
            unique case (mode)
                TRG_LOW:  hit = ~cur;
                TRG_HIGH: hit = cur;
                TRG_RISE: hit = cur & ~prev;
                TRG_FALL: hit = ~cur & prev;
                default:  hit = 1'b0;
            endcase
        end
        return hit;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] prev
);

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
            prev <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            prev <= chain[STAGES-1];
        end
    end

    assign cur = chain[STAGES-1];

endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
    import gpio_bank_pkg::*;
(
    input  logic [NUM_PINS-1:0] cur,
    input  logic [NUM_PINS-1:0] prev,
    input  logic [NUM_PINS-1:0] any_edge,
    input  logic [CFG_W-1:0]    cfg,
    output logic [NUM_PINS-1:0] hit
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        trig_mode_e mode;
        assign mode   = trig_mode_e'(cfg[p*MODE_W +: MODE_W]);
        assign hit[p] = trig_hit(mode, any_edge[p], cur[p], prev[p]);
    end

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_bank_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [IDX_W-1:0]    idx,
    input  logic [WORD_W-1:0]   wdata,
    input  logic [NUM_PINS-1:0] pad_level,
    input  logic [NUM_PINS-1:0] event_vec,
    output logic [NUM_PINS-1:0] dout_q,
    output logic [NUM_PINS-1:0] dir_q,
    output logic [NUM_PINS-1:0] mask_q,
    output logic [NUM_PINS-1:0] esel_q,
    output logic [NUM_PINS-1:0] status_q,
    output logic [CFG_W-1:0]    cfg_q,
    output logic [WORD_W-1:0]   rdata_q
);

    reg_idx_e            sel;
    logic [NUM_PINS-1:0] clr_vec;
    logic [WORD_W-1:0]   rd_word;

    assign sel     = reg_idx_e'(idx);
    assign clr_vec = (wr_en && sel == RG_STAT) ? wdata[NUM_PINS-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q <= '0;
            dir_q  <= '0;
            mask_q <= '0;
            esel_q <= '0;
            cfg_q  <= CFG_RESET;
        end else if (wr_en) begin
            unique case (sel)
                RG_DOUT:   dout_q <= wdata[NUM_PINS-1:0];
                RG_DIR:    dir_q  <= wdata[NUM_PINS-1:0];
                RG_CFG_LO: cfg_q[WORD_W-1:0] <= wdata;
                RG_CFG_HI: cfg_q[CFG_WORDS*WORD_W-1:WORD_W] <= wdata;
                RG_MASK:   mask_q <= wdata[NUM_PINS-1:0];
                RG_ESEL:   esel_q <= wdata[NUM_PINS-1:0];
                default:   ;
            endcase
        end
    end

    // a new event outranks a clear that lands on the same cycle
    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= (status_q & ~clr_vec) | event_vec;
    end

    always_comb begin
        unique case (sel)
            RG_DOUT:   rd_word = dout_q;
            RG_DIR:    rd_word = dir_q;
            RG_PAD:    rd_word = pad_level;
            RG_CFG_LO: rd_word = cfg_q[WORD_W-1:0];
            RG_CFG_HI: rd_word = cfg_q[CFG_WORDS*WORD_W-1:WORD_W];
            RG_MASK:   rd_word = mask_q;
            RG_STAT:   rd_word = status_q;
            RG_ESEL:   rd_word = esel_q;
            default:   rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_word;
    end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [IDX_W-1:0]    bus_addr,
    input  logic                bus_wr,
    input  logic [WORD_W-1:0]   bus_wdata,
    input  logic                bus_rd,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq_lo,
    output logic                irq_hi
);

    logic [NUM_PINS-1:0] pin_cur;
    logic [NUM_PINS-1:0] pin_prev;
    logic [NUM_PINS-1:0] event_vec;
    logic [NUM_PINS-1:0] status_q;
    logic [NUM_PINS-1:0] mask_q;
    logic [NUM_PINS-1:0] esel_q;
    logic [NUM_PINS-1:0] dout_q;
    logic [NUM_PINS-1:0] dir_q;
    logic [CFG_W-1:0]    cfg_q;
    logic [NUM_PINS-1:0] pending;

    gpio_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .d    (pin_in),
        .cur  (pin_cur),
        .prev (pin_prev)
    );

    gpio_trig_detect u_detect (
        .cur      (pin_cur),
        .prev     (pin_prev),
        .any_edge (esel_q),
        .cfg      (cfg_q),
        .hit      (event_vec)
    );

    gpio_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (bus_wr),
        .rd_en     (bus_rd),
        .idx       (bus_addr),
        .wdata     (bus_wdata),
        .pad_level (pin_cur),
        .event_vec (event_vec),
        .dout_q    (dout_q),
        .dir_q     (dir_q),
        .mask_q    (mask_q),
        .esel_q    (esel_q),
        .status_q  (status_q),
        .cfg_q     (cfg_q),
        .rdata_q   (bus_rdata)
    );

    assign pending = status_q & mask_q;
    assign irq_lo  = |pending[GROUP_W-1:0];
    assign irq_hi  = |pending[NUM_PINS-1:GROUP_W];
    assign pin_out = dout_q;
    assign pin_oe  = dir_q;

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_bank_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                bus_wr,
    input logic [IDX_W-1:0]    bus_addr,
    input logic [WORD_W-1:0]   bus_wdata,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic                irq_lo,
    input logic                irq_hi,
    input logic [NUM_PINS-1:0] status_q,
    input logic [NUM_PINS-1:0] mask_q,
    input logic [NUM_PINS-1:0] event_vec
);

    logic stat_wr;
    assign stat_wr = bus_wr && (bus_addr == RG_STAT);

    assert_oe_follows_dir_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == RG_DIR) |=> (pin_oe == $past(bus_wdata)));

    assert_status_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        !stat_wr |=> ((status_q & $past(status_q)) == $past(status_q)));

    assert_set_has_cause_R5: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((status_q & ~$past(status_q) & ~$past(event_vec)) == '0));

    assert_clear_acts_R7: assert property (@(posedge clk) disable iff (rst)
        stat_wr |=> ((status_q & $past(bus_wdata) & ~$past(event_vec)) == '0));

    assert_irq_needs_mask_R8: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> (!irq_lo && !irq_hi));

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        stat_wr |=> ((status_q & $past(event_vec)) == $past(event_vec)));

endmodule

bind gpio_irq_bank gpio_bank_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_oe    (pin_oe),
    .irq_lo    (irq_lo),
    .irq_hi    (irq_hi),
    .status_q  (status_q),
    .mask_q    (mask_q),
    .event_vec (event_vec)
);

// File: tb/gpio_irq_bank_bench.sv
module gpio_irq_bank_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq_lo, irq_hi;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    gpio_irq_bank u_gpio_irq_bank (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model built from the requirements
    logic [31:0] m_dout, m_dir, m_mask, m_esel, m_stat, m_rdata;
    logic [31:0] m_s1, m_s2, m_prev;
    logic [63:0] m_cfg;

    function automatic logic f_hit(logic [1:0] m, logic e, logic c, logic p);
        if (e) return c ^ p;
        case (m)
            2'd0:    return !c;
            2'd1:    return c;
            2'd2:    return c && !p;
            default: return !c && p;
        endcase
    endfunction

    function automatic logic [31:0] f_regval(logic [2:0] a);
        case (a)
            3'd0: return m_dout;
            3'd1: return m_dir;
            3'd2: return m_s2;
            3'd3: return m_cfg[31:0];
            3'd4: return m_cfg[63:32];
            3'd5: return m_mask;
            3'd6: return m_stat;
            default: return m_esel;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [31:0] ev, clr;
        if (rst) begin
            m_dout = 0; m_dir = 0; m_mask = 0; m_esel = 0; m_stat = 0;
            m_rdata = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
            m_cfg = {32{2'b01}};
        end else begin
            for (int p = 0; p < 32; p++)
                ev[p] = f_hit(m_cfg[2*p +: 2], m_esel[p], m_s2[p], m_prev[p]);
            if (bus_rd) m_rdata = f_regval(bus_addr);
            clr = (bus_wr && bus_addr == 3'd6) ? bus_wdata : 32'd0;
            m_stat = (m_stat & ~clr) | ev;
            if (bus_wr) begin
                case (bus_addr)
                    3'd0: m_dout = bus_wdata;
                    3'd1: m_dir = bus_wdata;
                    3'd3: m_cfg[31:0] = bus_wdata;
                    3'd4: m_cfg[63:32] = bus_wdata;
                    3'd5: m_mask = bus_wdata;
                    3'd7: m_esel = bus_wdata;
                    default: ;
                endcase
            end
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        bit did_rd;
        void'($urandom(32'd4711));
        idle(4);
        rst = 1'b0;

        // R1 reset state
        check("R1 pin_oe", pin_oe, 0);
        check("R1 pin_out", pin_out, 0);
        bus_read(0, d); check("R1 dout", d, 0);
        bus_read(1, d); check("R1 dir", d, 0);
        bus_read(3, d); check("R1 cfg lo", d, 32'h5555_5555);
        bus_read(4, d); check("R1 cfg hi", d, 32'h5555_5555);
        bus_read(5, d); check("R1 mask", d, 0);
        bus_read(6, d); check("R1 status", d, 0);
        bus_read(7, d); check("R1 esel", d, 0);

        // R2 output data and direction
        bus_write(0, 32'hA5A5_0F0F);
        bus_write(1, 32'hFFFF_0000);
        check("R2 pin_out", pin_out, 32'hA5A5_0F0F);
        check("R2 pin_oe", pin_oe, 32'hFFFF_0000);
        bus_read(1, d); check("R2 dir readback", d, 32'hFFFF_0000);

        // R3 synchronised pad level, two-read latency, write ignored
        @(negedge clk) pin_in = 32'h1234_5678;
        bus_read(2, d); check("R3 pad still old", d, 0);
        bus_read(2, d); check("R3 pad new", d, 32'h1234_5678);
        bus_write(2, 32'hFFFF_FFFF);
        bus_read(2, d); check("R3 pad write ignored", d, 32'h1234_5678);
        @(negedge clk) pin_in = 0;
        idle(4);
        bus_write(6, 32'hFFFF_FFFF);
        bus_read(6, d); check("R7 all ones clears", d, 0);

        // R4 / R10 pin 20 low-level via cfg hi bits [9:8]
        bus_write(4, 32'h5555_5455);
        idle(3);
        bus_write(6, 32'hFFFF_FFFF);
        bus_read(6, d); check("R4 R10 low level refires", d, 32'h0010_0000);
        @(negedge clk) pin_in = 32'h0010_0008;
        idle(3);
        @(negedge clk) pin_in = 32'h0010_0000;
        idle(4);
        bus_write(6, 32'h0010_0000);
        idle(1);
        bus_read(6, d); check("R4 sticky high level, R7 zeros keep", d, 32'h0000_0008);
        @(negedge clk) pin_in = 0;
        bus_write(4, 32'h5555_5555);
        idle(3);
        bus_write(6, 32'hFFFF_FFFF);

        // R5 / R10 pin 5 rising, pin 6 falling via cfg lo
        bus_write(3, 32'h5555_7955);
        idle(2);
        bus_write(6, 32'hFFFF_FFFF);
        @(negedge clk) pin_in = 32'h0000_0020;
        idle(4);
        bus_read(6, d); check("R5 R10 rising edge", d, 32'h0000_0020);
        bus_write(6, 32'hFFFF_FFFF);
        idle(3);
        bus_read(6, d); check("R5 once per edge", d, 0);
        @(negedge clk) pin_in = 32'h0000_0040;
        idle(4);
        bus_read(6, d); check("R5 opposite edges ignored", d, 0);
        @(negedge clk) pin_in = 0;
        idle(4);
        bus_read(6, d); check("R5 falling edge", d, 32'h0000_0040);
        bus_write(6, 32'hFFFF_FFFF);

        // R9 clear lands on the edge event cycle
        @(negedge clk) pin_in = 32'h0000_0020;
        @(negedge clk);
        @(negedge clk);
        bus_addr = 3'd6; bus_wdata = 32'h0000_0020; bus_wr = 1'b1;
        @(negedge clk) bus_wr = 1'b0;
        bus_read(6, d); check("R9 set wins over clear", d, 32'h0000_0020);
        @(negedge clk) pin_in = 0;
        idle(4);
        bus_write(6, 32'hFFFF_FFFF);

        // R6 edge select on pins 3 and 5
        bus_write(7, 32'h0000_0028);
        @(negedge clk) pin_in = 32'h0000_0028;
        idle(4);
        bus_read(6, d); check("R6 any edge rising", d, 32'h0000_0028);
        bus_write(6, 32'hFFFF_FFFF);
        idle(3);
        bus_read(6, d); check("R6 level ignored", d, 0);
        @(negedge clk) pin_in = 0;
        idle(4);
        bus_read(6, d); check("R6 falling on rise-mode pin", d, 32'h0000_0028);
        bus_write(7, 0);
        bus_write(6, 32'hFFFF_FFFF);

        // R8 mask and grouping, pins 2 and 17 pulsed in high mode
        @(negedge clk) pin_in = 32'h0002_0004;
        @(negedge clk) pin_in = 0;
        idle(4);
        check("R8 masked lo", irq_lo, 0);
        check("R8 masked hi", irq_hi, 0);
        bus_write(5, 32'h0000_0004);
        check("R8 lo group", irq_lo, 1);
        check("R8 hi idle", irq_hi, 0);
        bus_write(5, 32'h0002_0000);
        check("R8 lo masked", irq_lo, 0);
        check("R8 hi group", irq_hi, 1);
        bus_write(6, 32'h0000_0004);
        bus_read(6, d); check("R7 partial clear", d, 32'h0002_0000);
        check("R8 hi still pending", irq_hi, 1);
        bus_write(6, 32'h0002_0000);
        check("R8 hi cleared", irq_hi, 0);

        // random phase against the model
        did_rd = 0;
        for (int i = 0; i < 1500; i++) begin
            int r;
            @(negedge clk);
            check("R2 pin_out model", pin_out, m_dout);
            check("R2 pin_oe model", pin_oe, m_dir);
            check("R8 irq_lo model", {31'd0, irq_lo}, {31'd0, |(m_stat[15:0] & m_mask[15:0])});
            check("R8 irq_hi model", {31'd0, irq_hi}, {31'd0, |(m_stat[31:16] & m_mask[31:16])});
            if (did_rd) check("R4 R5 R6 R7 R9 read model", bus_rdata, m_rdata);
            bus_wr = 1'b0; bus_rd = 1'b0; did_rd = 0;
            if ($urandom % 3 == 0) pin_in = pin_in ^ (32'd1 << ($urandom % 32));
            r = $urandom % 10;
            if (r < 3) begin
                bus_addr = 3'($urandom % 8); bus_wdata = $urandom; bus_wr = 1'b1;
            end else if (r < 6) begin
                bus_addr = 3'($urandom % 8); bus_rd = 1'b1; did_rd = 1;
            end
        end
        @(negedge clk);
        if (did_rd) check("R4 R5 R6 R7 R9 read model", bus_rdata, m_rdata);
        bus_wr = 1'b0; bus_rd = 1'b0;
        finish_run();
    end

endmodule